// File: doc/BRIEF.md
# Manchester II Serial Word Encoder

This block turns one 16-bit serial data word into a Manchester II line frame and drives it on a pair of complementary bipolar outputs. A frame is twenty bit times long. It starts with a three-bit-time sync pattern whose polarity marks the frame as a command word or a data word. Sixteen Manchester-coded data bits follow, and the frame ends with an odd parity bit. The data bits come from an external serial source. The block gates that source with a request strobe and a bit-rate shift clock that it drives out.

Everything runs on one clock, `clk`. A parameterised prescaler derives the half-bit slot rate from it. With the default divide-by-six, `clk` is the twelve-times-bit-rate clock. With a divide of one, `clk` is the two-times send clock itself. Holding the enable high sends frames back to back with no gap. An active-low inhibit forces the line to its inactive state without disturbing the sequence. A master reset pulse aborts a frame at the next half-bit slot.

Top module: `manch_word_enc`

## Requirements
- R1: A half-bit slot lasts PRESCALE clocks. `shift_clk` changes level at every slot boundary: it is high during the first half of each bit time and low during the second half, so one bit time is 2*PRESCALE clocks.
- R2: `enc_enable` is sampled at the slot boundary where `shift_clk` rises. If it is high there while the encoder is idle, bit time 0 of a new frame begins in the slot that follows.
- R3: `sync_cmd` is sampled together with `enc_enable` at the start of a frame. With `sync_cmd` high (command), `bip_one` is high for the first three half-bit slots and low for the next three. With `sync_cmd` low (data), the pattern is inverted.
- R4: Within a frame whose bit times are numbered 0 to 19, `data_req` is high during bit times 2 through 17 (exactly sixteen bit times) and low otherwise.
- R5: The `ser_data` value present at the end of each requested bit time is sampled. It is sent in the following bit time, most significant bit first, in bit times 3 to 18. A one is sent as `bip_one` high then low, and a zero as low then high.
- R6: Bit time 19 carries a parity bit, encoded like a data bit, that makes the number of ones across the sixteen data bits and the parity bit odd.
- R7: If `enc_enable` is high at the boundary that ends bit time 19, the next frame starts in the very next slot with no gap. If it is low there, the encoder goes idle.
- R8: While `out_inhibit_n` is low, `bip_one` and `bip_zero` are both high. Inhibit has no effect on `shift_clk`, `data_req` or the frame sequence.
- R9: A slot boundary seen while `mrst` is high aborts any frame. The encoder returns to idle with the bit phase reset, exactly as after power-on reset.
- R10: When idle and not inhibited, both bipolar outputs are low. During a frame, `bip_zero` is always the complement of `bip_one`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: 12x bit rate with the default prescale, or 2x bit rate when PRESCALE is 1 |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enc_enable | input | 1 | Starts a frame when high at a bit boundary |
| sync_cmd | input | 1 | High selects command sync, low selects data sync |
| ser_data | input | 1 | Serial data from the external source |
| out_inhibit_n | input | 1 | Low forces both bipolar outputs high |
| mrst | input | 1 | Master reset that aborts the current frame |
| shift_clk | output | 1 | Bit-rate shift clock |
| data_req | output | 1 | High while the encoder wants serial data |
| bip_one | output | 1 | Bipolar-one line output |
| bip_zero | output | 1 | Bipolar-zero line output |

## Verification
The assertions assume that `mrst` is a synchronous level that lasts at least one full slot whenever it should act. They also assume that `ser_data` only matters where `data_req` asks for it. The stimulus changes every input on the falling clock edge and holds `mrst` for more than PRESCALE clocks. It drives deliberately toggling junk on `ser_data` outside the request window, so sampling outside that window would corrupt the frame. `enc_enable` and `sync_cmd` change at arbitrary slots, mid-frame, to show that they are sampled only at frame boundaries.

// File: rtl/manch_pkg.sv
package manch_pkg;

  // Line level of the sync pattern for a given half-bit slot within the
  // sync field. Command sync starts high; data sync starts low.
  function automatic logic sync_level(input logic cmd, input int slot, input int sync_bits);
    logic first_part;
    first_part = (slot < sync_bits);
    return cmd ? first_part : ~first_part;
  endfunction

endpackage

// File: rtl/manch_prescale.sv
module manch_prescale #(
  parameter int PRESCALE = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = (cnt_q == LAST);

      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    end
  endgenerate

endmodule

// File: rtl/manch_seq.sv
module manch_seq #(
  parameter int DATA_BITS = 16,
  parameter int SYNC_BITS = 3,
  localparam int FRAME_BITS = SYNC_BITS + DATA_BITS + 1,
  localparam int IW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          sync_sel,
  input  logic          sdi,
  input  logic          mrst,
  output logic          busy,
  output logic [IW-1:0] bit_idx,
  output logic          ph,
  output logic          cmd,
  output logic          tx_bit,
  output logic          data_req
);

  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] REQ_LO   = IW'(SYNC_BITS - 1);
  localparam logic [IW-1:0] REQ_HI   = IW'(SYNC_BITS + DATA_BITS - 2);
  localparam logic [IW-1:0] PRE_PAR  = IW'(SYNC_BITS + DATA_BITS - 1);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          ph_q, ph_d;
  logic          cmd_q, cmd_d;
  logic          tx_q, tx_d;
  logic          par_q, par_d;
  logic          req;
  logic          boundary;

  assign req      = busy_q && (idx_q >= REQ_LO) && (idx_q <= REQ_HI);
  assign boundary = tick && !mrst && ph_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    ph_d   = ph_q;
    cmd_d  = cmd_q;
    tx_d   = tx_q;
    par_d  = par_q;
    if (tick) begin
      if (mrst) begin
        busy_d = 1'b0;
        idx_d  = '0;
        ph_d   = 1'b0;
        cmd_d  = 1'b0;
        tx_d   = 1'b0;
        par_d  = 1'b0;
      end else begin
        ph_d = ~ph_q;
        if (ph_q) begin
          if (busy_q && idx_q != LAST_IDX) begin
            idx_d = idx_q + 1'b1;
            if (req) begin
              tx_d  = sdi;
              par_d = par_q ^ sdi;
            end
            if (idx_q == PRE_PAR) tx_d = ~par_q;
          end else begin
            busy_d = enable;
            idx_d  = '0;
            cmd_d  = sync_sel;
            par_d  = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      ph_q   <= 1'b0;
      cmd_q  <= 1'b0;
      tx_q   <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      ph_q   <= ph_d;
      cmd_q  <= cmd_d;
      tx_q   <= tx_d;
      par_q  <= par_d;
    end
  end

  assign busy     = busy_q;
  assign bit_idx  = idx_q;
  assign ph       = ph_q;
  assign cmd      = cmd_q;
  assign tx_bit   = tx_q;
  assign data_req = req;

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ph_q) && $stable(idx_q) && $stable(busy_q)); // R1
  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && busy_q && idx_q != LAST_IDX |=> busy_q && idx_q == $past(idx_q) + 1'b1); // R2
  AST_REQ_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> busy_q && idx_q == REQ_LO); // R4
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && busy_q && idx_q == LAST_IDX && enable |=> busy_q && idx_q == '0); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && mrst |=> !busy_q && !ph_q); // R9

endmodule

// File: rtl/manch_line.sv
module manch_line #(
  parameter int SYNC_BITS = 3,
  parameter int IW = 5
) (
  input  logic          busy,
  input  logic [IW-1:0] bit_idx,
  input  logic          ph,
  input  logic          cmd,
  input  logic          tx_bit,
  input  logic          inhibit_n,
  output logic          line_one,
  output logic          line_zero
);

  import manch_pkg::*;

  logic level;
  int   slot;

  always_comb begin
    slot = int'(bit_idx) * 2 + int'(ph);
    if (int'(bit_idx) < SYNC_BITS) level = sync_level(cmd, slot, SYNC_BITS);
    else                           level = tx_bit ^ ph;
  end

  always_comb begin
    if (!inhibit_n) begin
      line_one  = 1'b1;
      line_zero = 1'b1;
    end else if (busy) begin
      line_one  = level;
      line_zero = ~level;
    end else begin
      line_one  = 1'b0;
      line_zero = 1'b0;
    end
  end

endmodule

// File: rtl/manch_word_enc.sv
module manch_word_enc #(
  parameter int PRESCALE  = 6,
  parameter int DATA_BITS = 16,
  parameter int SYNC_BITS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enc_enable,
  input  logic sync_cmd,
  input  logic ser_data,
  input  logic out_inhibit_n,
  input  logic mrst,
  output logic shift_clk,
  output logic data_req,
  output logic bip_one,
  output logic bip_zero
);

  localparam int FRAME_BITS = SYNC_BITS + DATA_BITS + 1;
  localparam int IW = $clog2(FRAME_BITS);

  logic          tick;
  logic          busy;
  logic [IW-1:0] bit_idx;
  logic          ph;
  logic          cmd;
  logic          tx_bit;

  manch_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  manch_seq #(.DATA_BITS(DATA_BITS), .SYNC_BITS(SYNC_BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .enable   (enc_enable),
    .sync_sel (sync_cmd),
    .sdi      (ser_data),
    .mrst     (mrst),
    .busy     (busy),
    .bit_idx  (bit_idx),
    .ph       (ph),
    .cmd      (cmd),
    .tx_bit   (tx_bit),
    .data_req (data_req)
  );

  manch_line #(.SYNC_BITS(SYNC_BITS), .IW(IW)) u_line (
    .busy      (busy),
    .bit_idx   (bit_idx),
    .ph        (ph),
    .cmd       (cmd),
    .tx_bit    (tx_bit),
    .inhibit_n (out_inhibit_n),
    .line_one  (bip_one),
    .line_zero (bip_zero)
  );

  assign shift_clk = ~ph;

  AST_INHIBIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !out_inhibit_n |-> bip_one && bip_zero); // R8
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_inhibit_n && !busy |-> !bip_one && !bip_zero); // R10
  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    out_inhibit_n && busy |-> bip_one != bip_zero); // R10
  AST_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> busy); // R4

endmodule

// File: tb/manch_word_enc_tb.sv
module manch_word_enc_tb;

  localparam int DIV = 6;
  localparam int NSLOT = 40;

  logic clk, rst_n;
  logic enc_enable, sync_cmd, ser_data, out_inhibit_n, mrst;
  logic shift_clk, data_req, bip_one, bip_zero;

  manch_word_enc #(.PRESCALE(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .enc_enable(enc_enable), .sync_cmd(sync_cmd),
    .ser_data(ser_data), .out_inhibit_n(out_inhibit_n), .mrst(mrst),
    .shift_clk(shift_clk), .data_req(data_req), .bip_one(bip_one), .bip_zero(bip_zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [15:0] words [8] = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001,
                             16'h1234, 16'h7FFE, 16'h0F0F, 16'hC33C};
  int widx = 0;
  logic [15:0] cur_word;

  // behavioural reference model
  int pc, slot;
  bit mph, b2b, aborted;
  bit wave [NSLOT];
  bit junk;

  task automatic build_wave(input bit c, input logic [15:0] w);
    for (int s = 0; s < 6; s++) wave[s] = c ? (s < 3) : (s >= 3);
    for (int i = 0; i < 16; i++) begin
      wave[6 + 2*i] = w[15 - i];
      wave[7 + 2*i] = !w[15 - i];
    end
    wave[38] = !(^w);
    wave[39] = (^w);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc = 0; mph = 0; slot = -1; b2b = 0; aborted = 0;
    end else begin
      bit tk, old;
      tk = (pc == DIV - 1);
      pc = tk ? 0 : pc + 1;
      if (tk) begin
        if (mrst) begin
          mph = 0; slot = -1; b2b = 0; aborted = 1;
        end else begin
          old = mph;
          mph = !mph;
          if (slot >= 0 && slot < NSLOT - 1) slot++;
          else if (old) begin
            if (enc_enable) begin
              b2b = (slot == NSLOT - 1);
              aborted = 0;
              slot = 0;
              cur_word = words[widx % 8];
              widx++;
              build_wave(sync_cmd, cur_word);
            end else slot = -1;
          end
        end
      end
    end
  end

  // serial source: real bits inside the request window, junk elsewhere
  always @(negedge clk) begin
    junk <= ~junk;
    if (slot >= 4 && slot <= 35) ser_data <= cur_word[15 - (slot/2 - 2)];
    else ser_data <= junk;
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b slot=%0d t=%0t", req, what, act, exp, slot, $time);
    end
  endtask

  function automatic string level_tag();
    if (!out_inhibit_n) return "R8";
    if (slot < 0) return aborted ? "R9" : "R10";
    if (slot < 2) return b2b ? "R7" : "R2";
    if (slot < 6) return "R3";
    if (slot < 38) return "R5";
    return "R6";
  endfunction

  // compare every clock, shortly after the active edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic e1, e0;
      string t;
      t = level_tag();
      if (!out_inhibit_n) begin e1 = 1; e0 = 1; end
      else if (slot >= 0) begin e1 = wave[slot]; e0 = !wave[slot]; end
      else begin e1 = 0; e0 = 0; end
      check("R1", shift_clk, !mph, "shift_clk");
      check("R4", data_req, (slot >= 4 && slot <= 35), "data_req");
      check(t, bip_one, e1, "bip_one");
      check(slot >= 0 && out_inhibit_n ? "R10" : t, bip_zero, e0, "bip_zero");
    end
  end

  task automatic wait_slot(input int n);
    while (slot != n) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (slot != -1) @(negedge clk);
  endtask

  task automatic idle_clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; enc_enable = 0; sync_cmd = 0; out_inhibit_n = 1; mrst = 0; junk = 0; ser_data = 0;
    idle_clocks(3);
    rst_n = 1;
    idle_clocks(2);
    // reset state: idle line low, no request (R10, R4)
    check("R10", bip_one, 1'b0, "reset bip_one");
    check("R10", bip_zero, 1'b0, "reset bip_zero");
    check("R4", data_req, 1'b0, "reset data_req");
    idle_clocks(30);

    // single data-sync frame (R2, R3, R5, R6)
    sync_cmd = 0; enc_enable = 1;
    wait_slot(2); enc_enable = 0; sync_cmd = 1;
    wait_idle(); idle_clocks(25);

    // single command-sync frame, sync select toggled mid-frame (R3)
    sync_cmd = 1; enc_enable = 1;
    wait_slot(3); enc_enable = 0; sync_cmd = 0;
    wait_idle(); idle_clocks(17);

    // back-to-back frames with inhibit pulse in the middle (R7, R8)
    enc_enable = 1; sync_cmd = 0;
    wait_slot(10); sync_cmd = 1;
    wait_slot(0);  sync_cmd = 0;
    wait_slot(20); out_inhibit_n = 0;
    idle_clocks(23); out_inhibit_n = 1;
    wait_slot(0); sync_cmd = 1;
    wait_slot(30); enc_enable = 0;
    wait_idle(); idle_clocks(20);

    // inhibit while idle (R8)
    out_inhibit_n = 0; idle_clocks(9); out_inhibit_n = 1; idle_clocks(9);

    // abort by master reset mid-frame, then a fresh frame (R9)
    enc_enable = 1; sync_cmd = 0;
    wait_slot(14); enc_enable = 0; mrst = 1;
    idle_clocks(DIV + 2); mrst = 0;
    idle_clocks(40);
    enc_enable = 1; sync_cmd = 1;
    wait_slot(1); enc_enable = 0;
    wait_idle(); idle_clocks(20);

    // two more back-to-back frames covering the remaining words (R7)
    enc_enable = 1;
    wait_slot(5); wait_slot(0); wait_slot(20); enc_enable = 0;
    wait_idle(); idle_clocks(20);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule